// File: doc/BRIEF.md
# Prescaled Serial-Clock Edge Divider

This block turns the bus clock into the edge timing for a serial-peripheral master. An 8-bit divider setting holds two fields: a linear prescale factor and a power-of-two rate select. The serial clock period is their product in bus cycles:

D = (prescale + 1) × 2^(rate + 1).

Because the prescale factor need not be a power of two, ratios such as 1792 are possible. The block does not drive the serial clock line. Instead it raises a one-cycle edge strobe every D/2 bus cycles. It also marks whether that strobe is the leading or the trailing edge of a serial clock period. The shift engine uses these strobes to toggle its clock and move data.

The shift engine holds `run` high for the length of a transfer. While `run` is low, the divider stays at rest, its count is cleared, and it picks up the divider setting. The setting is therefore frozen for the whole of a transfer.

Top module: `spi_baud_div`

## Requirements
- R1: The prescale field P is `baud_cfg[6:4]` and the rate field R is `baud_cfg[3:0]`. Bit 7 has no effect: 0x83 gives the same timing as 0x03.
- R2: While `run` is high, `edge_tick` pulses for one cycle every H = (P+1)·2^R bus cycles, where H is half of the divisor. Examples: 0x00 gives H=1 (÷2), 0x03 gives H=8 (÷16), 0x25 gives H=96, 0x67 gives H=896 (÷1792), 0x70 gives H=8 (÷16) and 0x77 gives H=1024 (÷2048).
- R3: Rate values from 8 to 15 act as 7. 0x0F gives H=128 and 0x3C gives H=512, so the slowest rate stays at bus/2048.
- R4: The first `edge_tick` of a run comes in the H-th cycle with `run` high, counting the first such cycle as 1.
- R5: `edge_tick` and `edge_lead` stay low while `run` is low. Dropping `run` for one cycle discards any partial count, so the next run again takes a full H cycles to its first tick.
- R6: The setting used during a run is the value of `baud_cfg` in the last cycle before `run` rose. A change of `baud_cfg` while `run` is high has no effect until the next run.
- R7: `edge_lead` is high with the 1st, 3rd, 5th, … tick of a run and low with the even-numbered ticks. It is never high without `edge_tick`.
- R8: While `rst_n` is low, both outputs are low. After reset the held setting is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_cfg | input | 8 | Divider setting: prescale in [6:4], rate in [3:0] |
| run | input | 1 | High while the shift engine is transferring |
| edge_tick | output | 1 | One-cycle strobe for each serial clock edge |
| edge_lead | output | 1 | High when this strobe is the leading edge of a period |

## Verification
The assertions assume that `run` is a clean, synchronous level from the shift engine. They also assume it is held low during reset, so that the first cycle after reset starts from an idle divider. The bench drives `run` and `baud_cfg` one time unit after a rising edge and holds `run` low throughout reset. It changes `baud_cfg` both while idle and in the middle of a run, since the frozen-setting property has to tolerate arbitrary setting changes while a transfer is in progress.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;

  // Rate select after clamping to the largest supported exponent.
  function automatic int clamp_rate(input int rate, input int rate_max);
    return (rate > rate_max) ? rate_max : rate;
  endfunction

  // Bus cycles between consecutive serial clock edges (half the divisor).
  function automatic int half_period(input int pre, input int rate, input int rate_max);
    return (pre + 1) << clamp_rate(rate, rate_max);
  endfunction

endpackage

// File: rtl/spi_baud_cfg_hold.sv
module spi_baud_cfg_hold #(
  parameter int PRE_W  = 3,
  parameter int RATE_W = 4,
  localparam int CFG_W = 1 + PRE_W + RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CFG_W-1:0]  baud_cfg,
  output logic [PRE_W-1:0]  pre_q,
  output logic [RATE_W-1:0] rate_q
);

  // Follows the setting only while idle; frozen for the length of a run.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      rate_q <= '0;
    end else if (!run) begin
      pre_q  <= baud_cfg[RATE_W +: PRE_W];
      rate_q <= baud_cfg[RATE_W-1:0];
    end
  end

endmodule

// File: rtl/spi_baud_edge_counter.sv
module spi_baud_edge_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half,
  output logic             tick,
  output logic [CNT_W-1:0] cnt
);

  logic at_end;

  assign at_end = (cnt == (half - CNT_W'(1)));
  assign tick   = run && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/spi_baud_edge_phase.sv
module spi_baud_edge_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic phase,
  output logic lead
);

  assign lead = tick && !phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 1'b0;
    end else if (!run) begin
      phase <= 1'b0;
    end else if (tick) begin
      phase <= ~phase;
    end
  end

endmodule

// File: rtl/spi_baud_div.sv
module spi_baud_div #(
  parameter int PRE_W    = 3,
  parameter int RATE_W   = 4,
  parameter int RATE_MAX = 7,
  localparam int CFG_W   = 1 + PRE_W + RATE_W,
  localparam int CNT_W   = PRE_W + RATE_MAX + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] baud_cfg,
  input  logic             run,
  output logic             edge_tick,
  output logic             edge_lead
);

  // Named internal events, exposed for the bound checker.
  logic [PRE_W-1:0]  pre_q;
  logic [RATE_W-1:0] rate_q;
  logic [CNT_W-1:0]  half_w;
  logic [CNT_W-1:0]  cnt_w;
  logic              phase_w;
  logic              tick_w;
  logic              lead_w;

  spi_baud_cfg_hold #(.PRE_W(PRE_W), .RATE_W(RATE_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .run(run), .baud_cfg(baud_cfg),
    .pre_q(pre_q), .rate_q(rate_q)
  );

  assign half_w = CNT_W'(spi_baud_pkg::half_period(int'(pre_q), int'(rate_q), RATE_MAX));

  spi_baud_edge_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .run(run), .half(half_w),
    .tick(tick_w), .cnt(cnt_w)
  );

  spi_baud_edge_phase phase_i (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick_w),
    .phase(phase_w), .lead(lead_w)
  );

  assign edge_tick = tick_w;
  assign edge_lead = lead_w;

endmodule

// File: rtl/spi_baud_div_chk.sv
module spi_baud_div_chk #(
  parameter int PRE_W    = 3,
  parameter int RATE_W   = 4,
  parameter int RATE_MAX = 7,
  parameter int CNT_W    = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              edge_tick,
  input logic              edge_lead,
  input logic [CNT_W-1:0]  cnt_w,
  input logic [CNT_W-1:0]  half_w,
  input logic [PRE_W-1:0]  pre_q,
  input logic [RATE_W-1:0] rate_q
);

  localparam logic [CNT_W:0] HALF_CAP = (CNT_W+1)'(1) << (PRE_W + RATE_MAX);

  // Independent tracking: cycles since start or last tick, and edge parity.
  logic [CNT_W:0] since;
  logic           odd;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      since <= '0;
      odd   <= 1'b0;
    end else if (edge_tick) begin
      since <= '0;
      odd   <= ~odd;
    end else begin
      since <= since + (CNT_W+1)'(1);
    end
  end

  p_quiet_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!edge_tick && !edge_lead));

  p_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_tick |-> (since == {1'b0, half_w} - (CNT_W+1)'(1)));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_w < half_w);

  p_half_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, half_w} <= HALF_CAP) && (half_w != '0));

  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_w == '0));

  p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ($stable(pre_q) && $stable(rate_q)));

  p_lead_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
    edge_tick |-> (edge_lead == !odd));

  p_lead_needs_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    edge_lead |-> edge_tick);

endmodule

bind spi_baud_div spi_baud_div_chk #(
  .PRE_W(PRE_W), .RATE_W(RATE_W), .RATE_MAX(RATE_MAX), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run),
  .edge_tick(edge_tick), .edge_lead(edge_lead),
  .cnt_w(cnt_w), .half_w(half_w), .pre_q(pre_q), .rate_q(rate_q)
);

// File: tb/spi_baud_div_tb.sv
`timescale 1ns/1ps
module spi_baud_div_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic       edge_tick;
  logic       edge_lead;

  int checks = 0;
  int errors = 0;

  // Reference model state
  int m_cnt = 0;
  int m_edges = 0;
  int m_cfg = 0;

  always #4 clk = ~clk;

  spi_baud_div dut_i (
    .clk(clk), .rst_n(rst_n), .baud_cfg(cfg), .run(run),
    .edge_tick(edge_tick), .edge_lead(edge_lead)
  );

  // Half period from the requirement text: (P+1) doubled R times, R capped at 7.
  function automatic int ref_half(input int v);
    int p = (v / 16) % 8;
    int r = v % 16;
    int h = p + 1;
    if (r > 7) r = 7;
    for (int i = 0; i < r; i++) h = h * 2;
    return h;
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_edges = 0; m_cfg = 0;
    end else if (!run) begin
      m_cnt = 0; m_edges = 0; m_cfg = int'(cfg);
    end else if (m_cnt + 1 == ref_half(m_cfg)) begin
      m_cnt = 0; m_edges++;
    end else begin
      m_cnt++;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      check("R8", int'(edge_tick), 0, "tick in reset");
      check("R8", int'(edge_lead), 0, "lead in reset");
    end else begin
      int exp_t, exp_l;
      exp_t = (run && (m_cnt + 1 == ref_half(m_cfg))) ? 1 : 0;
      exp_l = (exp_t == 1 && (m_edges % 2) == 0) ? 1 : 0;
      if (!run)              check("R5", int'(edge_tick), exp_t, "idle tick");
      else if (m_edges == 0) check("R4", int'(edge_tick), exp_t, "first tick");
      else                   check("R2", int'(edge_tick), exp_t, "tick");
      check("R7", int'(edge_lead), exp_l, "lead");
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Start a run from idle with setting v; return cycles up to and including the first tick.
  task automatic first_tick(input int v, output int n);
    cfg = v[7:0]; run = 1'b0;
    step(3);
    run = 1'b1;
    n = 0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      n++;
      if (edge_tick) break;
    end
    step(1);
    run = 1'b0;
  endtask

  task automatic count_ticks(input int cycles, output int ticks, output int leads);
    ticks = 0; leads = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      ticks += int'(edge_tick);
      leads += int'(edge_lead);
    end
  endtask

  initial begin
    #(8.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, t, l;
    step(4);
    rst_n = 1'b1;
    step(2);

    first_tick(8'h00, n); check("R2", n, 1, "0x00 half period");
    first_tick(8'h03, n); check("R2", n, 8, "0x03 half period");
    first_tick(8'h70, n); check("R2", n, 8, "0x70 half period");
    first_tick(8'h25, n); check("R2", n, 96, "0x25 half period");
    first_tick(8'h67, n); check("R2", n, 896, "0x67 half period");
    first_tick(8'h77, n); check("R2", n, 1024, "0x77 half period");
    first_tick(8'h83, n); check("R1", n, 8, "bit7 ignored 0x83");
    first_tick(8'h0F, n); check("R3", n, 128, "rate clamp 0x0F");
    first_tick(8'h3C, n); check("R3", n, 512, "rate clamp 0x3C");

    // R5: partial count discarded after a one-cycle idle gap
    cfg = 8'h03; step(2);
    run = 1'b1; step(5);
    run = 1'b0; step(1);
    run = 1'b1;
    n = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk); n++;
      if (edge_tick) break;
    end
    check("R5", n, 8, "restart after gap");
    step(1); run = 1'b0;

    // R5: idle with fastest setting gives no ticks
    cfg = 8'h00;
    count_ticks(10, t, l);
    check("R5", t, 0, "idle ticks");

    // R6: setting change during run ignored
    cfg = 8'h01; step(2);
    run = 1'b1; step(3);
    cfg = 8'h77;
    count_ticks(20, t, l);
    check("R6", t, 10, "ticks after mid-run change");
    step(1); run = 1'b0;
    first_tick(8'h04, n); check("R6", n, 16, "new setting on next run");

    // R7: alternating lead flag at fastest rate
    cfg = 8'h00; step(2);
    run = 1'b1;
    count_ticks(6, t, l);
    check("R7", t, 6, "tick count fast");
    check("R7", l, 3, "lead count fast");
    step(1); run = 1'b0;

    // R8: reset mid-run
    cfg = 8'h00; run = 1'b1; step(2);
    rst_n = 1'b0; run = 1'b0; step(1);
    @(negedge clk);
    check("R8", int'(edge_tick), 0, "tick after reset");
    rst_n = 1'b1; step(2);
    run = 1'b1;
    @(negedge clk);
    check("R8", int'(edge_tick), 1, "post-reset setting 0x00");
    step(1); run = 1'b0;
    step(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule